// File: doc/BRIEF.md
# Fixed-Page Byte Stack Controller

This block runs a byte-wide stack that lives in a single fixed 256-byte page, 0x0100 through 0x01FF, of a 16-bit address space. It keeps an 8-bit stack pointer (SP). Every stack access address is the page byte 0x01 placed above a byte taken from SP. On a push it drives the address, a write strobe and the byte to store, taken from either the accumulator or the status byte. On a pull it drives the address and later hands back the byte the memory returned, tagged with the destination register it was meant for.

The pointer moves down after a push and up before a pull. There is no full or empty indication, so the pointer wraps silently inside the page and older entries get overwritten. Two side operations work with an index register. One loads SP from it and changes no flag. The other copies SP out to it and reports zero and negative indications for the copied value. The memory is external and has one cycle of read latency.

Top module: `stk_page_ctrl`

## Requirements
- R1: After reset, sp_out is 0xFD, mem_we is 0, pull_valid is 0, x_valid is 0, and x_out, x_zero and x_neg are 0.
- R2: In a cycle with push_req high, mem_we is 1 and mem_addr is {0x01, SP}. mem_wdata is acc_in when reg_sel=0 and psr_in when reg_sel=1. SP is one lower in the next cycle.
- R3: In a cycle with pull_req high and push_req low, mem_we is 0 and mem_addr is {0x01, SP+1}. SP is one higher in the next cycle.
- R4: When a pull is accepted in cycle t, the memory returns data in cycle t+1. The block captures it, and pull_valid is high for exactly cycle t+2 with pull_data equal to the byte stored at the pulled address. In every other cycle pull_valid is 0.
- R5: SP wraps modulo 256. A push at SP=0x00 writes 0x0100 and leaves SP=0xFF. A pull at SP=0xFF reads 0x0100 and leaves SP=0x00.
- R6: When push_req and pull_req are both high, only the push happens. SP goes down by one and no pull_valid follows.
- R7: load_sp with neither push nor pull requested sets SP to x_in in the next cycle. It leaves x_out, x_zero and x_neg unchanged. A push or pull in the same cycle takes priority and the load is dropped.
- R8: copy_sp in cycle t makes x_valid high for exactly cycle t+1, with x_out equal to SP as it was in cycle t. In that same cycle x_zero is 1 exactly when that value is 0x00, and x_neg equals its bit 7. These outputs hold until the next copy.
- R9: pull_dst in the pull_valid cycle equals the reg_sel value of the pull request (0 = accumulator, 1 = status).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| push_req | input | 1 | One-cycle push strobe |
| pull_req | input | 1 | One-cycle pull strobe |
| reg_sel | input | 1 | Push source / pull destination: 0 accumulator, 1 status |
| acc_in | input | 8 | Accumulator value for pushes |
| psr_in | input | 8 | Status byte for pushes |
| x_in | input | 8 | Index register value for SP loads |
| load_sp | input | 1 | Load SP from x_in |
| copy_sp | input | 1 | Copy SP out to the index register |
| mem_rdata | input | 8 | Memory read data, one cycle after the address |
| mem_addr | output | 16 | Stack access address |
| mem_we | output | 1 | Memory write strobe |
| mem_wdata | output | 8 | Memory write data |
| sp_out | output | 8 | Current stack pointer |
| pull_valid | output | 1 | Pulled byte is ready this cycle |
| pull_dst | output | 1 | Destination register of the pulled byte |
| pull_data | output | 8 | Pulled byte |
| x_out | output | 8 | Copied SP value |
| x_valid | output | 1 | Copy result pulse |
| x_zero | output | 1 | Copied value is zero |
| x_neg | output | 1 | Bit 7 of copied value |

## Verification
The assertions assume three things about the environment. Requests are sampled only outside reset. mem_rdata follows the presented address with exactly one cycle of latency. The inputs hold steady through each clock edge. The stimulus drives every input on the falling edge and holds them at zero during reset. It also pairs the block with a registered-read memory model, so the one-cycle return that the pull path relies on always holds. Random mixes deliberately include simultaneous push and pull requests and loads that collide with them, so the priority paths are exercised under the same assumptions.

// File: rtl/stk_pkg.sv
package stk_pkg;
    typedef enum logic [1:0] {
        OP_IDLE = 2'd0,
        OP_PUSH = 2'd1,
        OP_PULL = 2'd2,
        OP_LOAD = 2'd3
    } stk_op_e;

    typedef enum logic {
        SEL_ACC = 1'b0,
        SEL_PSR = 1'b1
    } stk_reg_e;
endpackage

// File: rtl/stk_arb.sv
module stk_arb
    import stk_pkg::*;
(
    input  logic    push_req,
    input  logic    pull_req,
    input  logic    load_sp,
    output stk_op_e op
);
    always_comb begin
        if (push_req)      op = OP_PUSH;
        else if (pull_req) op = OP_PULL;
        else if (load_sp)  op = OP_LOAD;
        else               op = OP_IDLE;
    end
endmodule

// File: rtl/stk_sp_unit.sv
module stk_sp_unit
    import stk_pkg::*;
#(
    parameter int                 PTR_W    = 8,
    parameter logic [PTR_W-1:0]   SP_RESET = 8'hFD
) (
    input  logic             clk,
    input  logic             rst_n,
    input  stk_op_e          op,
    input  logic [PTR_W-1:0] load_val,
    output logic [PTR_W-1:0] sp,
    output logic [PTR_W-1:0] acc_ptr
);
    localparam logic [PTR_W-1:0] STEP = 1;

    typedef struct packed {
        logic [PTR_W-1:0] sp;
    } sp_state_t;

    sp_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        unique case (op)
            OP_PUSH: st_d.sp = st_q.sp - STEP;
            OP_PULL: st_d.sp = st_q.sp + STEP;
            OP_LOAD: st_d.sp = load_val;
            default: st_d.sp = st_q.sp;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '{sp: SP_RESET};
        else        st_q <= st_d;
    end

    assign sp      = st_q.sp;
    assign acc_ptr = (op == OP_PULL) ? (st_q.sp + STEP) : st_q.sp;
endmodule

// File: rtl/stk_pull_pipe.sv
module stk_pull_pipe #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              take,
    input  logic              dst_in,
    input  logic [DATA_W-1:0] rdata,
    output logic              valid,
    output logic              dst,
    output logic [DATA_W-1:0] data
);
    typedef struct packed {
        logic              pend;
        logic              pend_dst;
        logic              valid;
        logic              dst;
        logic [DATA_W-1:0] data;
    } pipe_state_t;

    pipe_state_t st_d, st_q;

    always_comb begin
        st_d          = st_q;
        st_d.pend     = take;
        st_d.pend_dst = take ? dst_in : st_q.pend_dst;
        st_d.valid    = st_q.pend;
        if (st_q.pend) begin
            st_d.data = rdata;
            st_d.dst  = st_q.pend_dst;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign valid = st_q.valid;
    assign dst   = st_q.dst;
    assign data  = st_q.data;
endmodule

// File: rtl/stk_sp_copy.sv
module stk_sp_copy #(
    parameter int PTR_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             copy,
    input  logic [PTR_W-1:0] sp,
    output logic [PTR_W-1:0] x_val,
    output logic             x_valid,
    output logic             x_zero,
    output logic             x_neg
);
    typedef struct packed {
        logic [PTR_W-1:0] val;
        logic             valid;
        logic             zero;
        logic             neg;
    } copy_state_t;

    copy_state_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.valid = copy;
        if (copy) begin
            st_d.val  = sp;
            st_d.zero = (sp == '0);
            st_d.neg  = sp[PTR_W-1];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign x_val   = st_q.val;
    assign x_valid = st_q.valid;
    assign x_zero  = st_q.zero;
    assign x_neg   = st_q.neg;
endmodule

// File: rtl/stk_page_ctrl.sv
module stk_page_ctrl
    import stk_pkg::*;
#(
    parameter int                       ADDR_W   = 16,
    parameter int                       DATA_W   = 8,
    parameter int                       PTR_W    = 8,
    parameter logic [ADDR_W-PTR_W-1:0]  PAGE_HI  = 8'h01,
    parameter logic [PTR_W-1:0]         SP_RESET = 8'hFD
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push_req,
    input  logic              pull_req,
    input  logic              reg_sel,
    input  logic [DATA_W-1:0] acc_in,
    input  logic [DATA_W-1:0] psr_in,
    input  logic [PTR_W-1:0]  x_in,
    input  logic              load_sp,
    input  logic              copy_sp,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_we,
    output logic [DATA_W-1:0] mem_wdata,
    output logic [PTR_W-1:0]  sp_out,
    output logic              pull_valid,
    output logic              pull_dst,
    output logic [DATA_W-1:0] pull_data,
    output logic [PTR_W-1:0]  x_out,
    output logic              x_valid,
    output logic              x_zero,
    output logic              x_neg
);
    stk_op_e          op;
    logic [PTR_W-1:0] acc_ptr;

    stk_arb u_arb (
        .push_req (push_req),
        .pull_req (pull_req),
        .load_sp  (load_sp),
        .op       (op)
    );

    stk_sp_unit #(.PTR_W(PTR_W), .SP_RESET(SP_RESET)) u_sp (
        .clk      (clk),
        .rst_n    (rst_n),
        .op       (op),
        .load_val (x_in),
        .sp       (sp_out),
        .acc_ptr  (acc_ptr)
    );

    stk_pull_pipe #(.DATA_W(DATA_W)) u_pull (
        .clk    (clk),
        .rst_n  (rst_n),
        .take   (op == OP_PULL),
        .dst_in (reg_sel),
        .rdata  (mem_rdata),
        .valid  (pull_valid),
        .dst    (pull_dst),
        .data   (pull_data)
    );

    stk_sp_copy #(.PTR_W(PTR_W)) u_copy (
        .clk     (clk),
        .rst_n   (rst_n),
        .copy    (copy_sp),
        .sp      (sp_out),
        .x_val   (x_out),
        .x_valid (x_valid),
        .x_zero  (x_zero),
        .x_neg   (x_neg)
    );

    assign mem_addr  = {PAGE_HI, acc_ptr};
    assign mem_we    = (op == OP_PUSH);
    assign mem_wdata = (reg_sel == SEL_PSR) ? psr_in : acc_in;
endmodule

// File: rtl/stk_page_chk.sv
module stk_page_chk #(
    parameter int                       ADDR_W   = 16,
    parameter int                       DATA_W   = 8,
    parameter int                       PTR_W    = 8,
    parameter logic [ADDR_W-PTR_W-1:0]  PAGE_HI  = 8'h01,
    parameter logic [PTR_W-1:0]         SP_RESET = 8'hFD
) (
    input logic              clk,
    input logic              rst_n,
    input logic              push_req,
    input logic              pull_req,
    input logic              reg_sel,
    input logic [DATA_W-1:0] acc_in,
    input logic [DATA_W-1:0] psr_in,
    input logic [PTR_W-1:0]  x_in,
    input logic              load_sp,
    input logic              copy_sp,
    input logic [DATA_W-1:0] mem_rdata,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_we,
    input logic [DATA_W-1:0] mem_wdata,
    input logic [PTR_W-1:0]  sp_out,
    input logic              pull_valid,
    input logic              pull_dst,
    input logic [DATA_W-1:0] pull_data,
    input logic [PTR_W-1:0]  x_out,
    input logic              x_valid,
    input logic              x_zero,
    input logic              x_neg
);
    localparam logic [PTR_W-1:0] ONE = 1;

    // R2: push drives write at {page, SP} with the selected source, SP falls
    p_push_addr_r2: assert property (@(posedge clk) disable iff (!rst_n)
        push_req |-> (mem_we && mem_addr == {PAGE_HI, sp_out}
                      && mem_wdata == (reg_sel ? psr_in : acc_in)));
    p_push_dec_r2: assert property (@(posedge clk) disable iff (!rst_n)
        push_req |=> (sp_out == $past(sp_out) - ONE));

    // R3: pull reads {page, SP+1}, SP rises
    p_pull_addr_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (pull_req && !push_req) |-> (!mem_we && mem_addr == {PAGE_HI, sp_out + ONE}));
    p_pull_inc_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (pull_req && !push_req) |=> (sp_out == $past(sp_out) + ONE));

    // R4: valid two cycles after an accepted pull, carrying the returned byte
    p_pull_valid_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (pull_req && !push_req) |=> ##1 pull_valid);
    p_pull_data_r4: assert property (@(posedge clk) disable iff (!rst_n)
        pull_valid |-> (pull_data == $past(mem_rdata)));

    // R6: simultaneous requests act as a push
    p_prio_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (push_req && pull_req) |-> mem_we);

    // R7: load takes x_in and leaves the copy outputs alone
    p_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (load_sp && !push_req && !pull_req) |=> (sp_out == $past(x_in)));
    p_load_flags_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (load_sp && !copy_sp) |=> ($stable(x_out) && $stable(x_zero) && $stable(x_neg)));

    // R8: copy result reflects the pre-update SP
    p_copy_r8: assert property (@(posedge clk) disable iff (!rst_n)
        copy_sp |=> (x_valid && x_out == $past(sp_out)
                     && x_zero == ($past(sp_out) == '0)
                     && x_neg == $past(sp_out[PTR_W-1])));
endmodule

bind stk_page_ctrl stk_page_chk #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .PTR_W(PTR_W),
    .PAGE_HI(PAGE_HI), .SP_RESET(SP_RESET)
) u_chk (.*);

// File: tb/stk_page_ctrl_bench.sv
module stk_page_ctrl_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        push_req = 0, pull_req = 0, reg_sel = 0, load_sp = 0, copy_sp = 0;
    logic [7:0]  acc_in = 0, psr_in = 0, x_in = 0;
    logic [7:0]  mem_rdata;
    logic [15:0] mem_addr;
    logic        mem_we;
    logic [7:0]  mem_wdata, sp_out, pull_data, x_out;
    logic        pull_valid, pull_dst, x_valid, x_zero, x_neg;

    always #2.5 clk = ~clk;

    stk_page_ctrl u_stk_page_ctrl (.*);

    // registered-read memory model
    logic [7:0] mem [256];
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 256; i++) mem[i] <= 8'(i * 7 + 3);
            mem_rdata <= 8'h00;
        end else begin
            if (mem_we) mem[mem_addr[7:0]] <= mem_wdata;
            mem_rdata <= mem[mem_addr[7:0]];
        end
    end

    int errors = 0;
    int checks = 0;

    // bench model
    logic [7:0] ref_mem [256];
    logic [7:0] m_sp, m_x;
    logic       m_xv, m_xz, m_xn;
    logic       pv0, pv1, ps0, ps1;
    logic [7:0] pd0, pd1;

    function automatic logic [7:0] pick(input logic sel, input logic [7:0] a, input logic [7:0] p);
        return sel ? p : a;
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic step(input logic ph, input logic pl, input logic ld, input logic cp,
                        input logic sel, input logic [7:0] a, input logic [7:0] p,
                        input logic [7:0] x);
        logic do_push, do_pull, do_load;
        logic [7:0] nxt;
        @(negedge clk);
        chk("R2 sp_out", 32'(sp_out), 32'(m_sp));
        chk("R4 pull_valid", 32'(pull_valid), 32'(pv1));
        if (pv1) begin
            chk("R4 pull_data", 32'(pull_data), 32'(pd1));
            chk("R9 pull_dst", 32'(pull_dst), 32'(ps1));
        end
        chk("R8 x_valid", 32'(x_valid), 32'(m_xv));
        chk("R8 x_out", 32'(x_out), 32'(m_x));
        chk("R8 x_zero", 32'(x_zero), 32'(m_xz));
        chk("R8 x_neg", 32'(x_neg), 32'(m_xn));
        push_req = ph; pull_req = pl; load_sp = ld; copy_sp = cp;
        reg_sel = sel; acc_in = a; psr_in = p; x_in = x;
        #1;
        do_push = ph;
        do_pull = pl && !ph;
        do_load = ld && !ph && !pl;
        nxt = m_sp + 8'd1;
        chk(ph && pl ? "R6 mem_we" : "R2 mem_we", 32'(mem_we), 32'(do_push));
        if (do_push) begin
            chk(m_sp == 8'h00 ? "R5 push addr" : "R2 push addr", 32'(mem_addr), {16'h0, 8'h01, m_sp});
            chk("R2 wdata", 32'(mem_wdata), 32'(pick(sel, a, p)));
        end
        if (do_pull)
            chk(m_sp == 8'hFF ? "R5 pull addr" : "R3 pull addr", 32'(mem_addr), {16'h0, 8'h01, nxt});
        @(posedge clk);
        pv1 = pv0; pd1 = pd0; ps1 = ps0;
        pv0 = do_pull; pd0 = ref_mem[nxt]; ps0 = sel;
        m_xv = cp;
        if (cp) begin m_x = m_sp; m_xz = (m_sp == 8'h00); m_xn = m_sp[7]; end
        if (do_push) begin ref_mem[m_sp] = pick(sel, a, p); m_sp = m_sp - 8'd1; end
        else if (do_pull) m_sp = nxt;
        else if (do_load) m_sp = x;
    endtask

    initial begin
        void'($urandom(32'd20240517));
        for (int i = 0; i < 256; i++) ref_mem[i] = 8'(i * 7 + 3);
        m_sp = 8'hFD; m_x = 0; m_xv = 0; m_xz = 0; m_xn = 0;
        pv0 = 0; pv1 = 0; ps0 = 0; ps1 = 0; pd0 = 0; pd1 = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        #1;
        chk("R1 sp_out", 32'(sp_out), 32'hFD);
        chk("R1 mem_we", 32'(mem_we), 0);
        chk("R1 pull_valid", 32'(pull_valid), 0);
        chk("R1 x_valid", 32'(x_valid), 0);
        chk("R1 x_out", 32'({x_out, x_zero, x_neg}), 0);
        // directed: push both sources, pull them back
        step(1, 0, 0, 0, 0, 8'hA1, 8'h55, 8'h00);
        step(1, 0, 0, 0, 1, 8'hA2, 8'h56, 8'h00);
        step(0, 1, 0, 0, 1, 8'h00, 8'h00, 8'h00);
        step(0, 1, 0, 0, 0, 8'h00, 8'h00, 8'h00);
        step(0, 0, 0, 0, 0, 8'h00, 8'h00, 8'h00);
        step(0, 0, 0, 0, 0, 8'h00, 8'h00, 8'h00);
        // R5 wrap on push at 0x00
        step(0, 0, 1, 0, 0, 8'h00, 8'h00, 8'h00);
        step(1, 0, 0, 1, 0, 8'h3C, 8'h00, 8'h00);
        step(0, 0, 0, 0, 0, 8'h00, 8'h00, 8'h00);
        chk("R5 sp after wrap push", 32'(sp_out), 32'hFF);
        chk("R8 copy zero flag", 32'(x_zero), 1);
        // R7 load leaves flags alone
        step(0, 0, 1, 0, 0, 8'h00, 8'h00, 8'h80);
        step(0, 0, 0, 0, 0, 8'h00, 8'h00, 8'h00);
        chk("R7 flags held", 32'({x_out, x_zero, x_neg}), {22'h0, 8'h00, 2'b10});
        chk("R7 sp loaded", 32'(sp_out), 32'h80);
        step(0, 0, 0, 1, 0, 8'h00, 8'h00, 8'h00);
        step(0, 0, 0, 0, 0, 8'h00, 8'h00, 8'h00);
        chk("R8 copy neg flag", 32'({x_zero, x_neg}), 32'b01);
        // R5 wrap on pull at 0xFF
        step(0, 0, 1, 0, 0, 8'h00, 8'h00, 8'hFF);
        step(0, 1, 0, 0, 1, 8'h00, 8'h00, 8'h00);
        step(0, 0, 0, 0, 0, 8'h00, 8'h00, 8'h00);
        chk("R5 sp after wrap pull", 32'(sp_out), 32'h00);
        // R6 both strobes, R7 load dropped under push
        step(1, 1, 1, 0, 0, 8'h99, 8'h00, 8'h44);
        step(0, 0, 0, 0, 0, 8'h00, 8'h00, 8'h00);
        step(0, 0, 0, 0, 0, 8'h00, 8'h00, 8'h00);
        chk("R6 no pull after both", 32'(pull_valid), 0);
        // random mix
        for (int n = 0; n < 4000; n++) begin
            logic [31:0] r;
            r = $urandom;
            step(r[2:0] < 3, r[5:3] < 3, r[8:6] == 0, r[11:9] == 0, r[12],
                 r[20:13], r[28:21], 8'($urandom));
        end
        repeat (3) step(0, 0, 0, 0, 0, 8'h00, 8'h00, 8'h00);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule